// File: doc/BRIEF.md
# Port Pin Peripheral Override Mux

This block is an 8-bit bidirectional I/O port. Each pin can be lent to an on-chip peripheral one bit at a time. A register bus writes two latches per bit. The output-value latch holds the level the port drives. The direction latch holds a 1 to float the pin or a 0 to drive it. The bus reads back either the pin levels, after a synchronizer, or the stored direction bits.

A per-bit peripheral select hands the pin to a peripheral. While a bit is selected, the pin takes its output value from the peripheral's data instead of the port latch. The peripheral may also force that pin to drive, or force it to float, whatever the direction latch holds. The direction latch itself is never modified by an override, so the stored setting governs again as soon as the select drops. The raw pin level is always passed to the peripheral input, whichever side owns the pin. It also feeds the synchronized port read path.

Top module: `pinmux_port`

## Requirements
- R1: After reset every direction bit reads 1, every output-value latch bit is 0, and every pin_oe bit is 0.
- R2: With periph_sel[i]=0, pin_oe[i] equals the inverse of direction bit i, and pin_out[i] equals output-value latch bit i.
- R3: With periph_sel[i]=1, pin_out[i] equals periph_dout[i], regardless of the output-value latch.
- R4: With periph_sel[i]=1, periph_force_out[i]=1 and periph_force_in[i]=0, pin_oe[i] is 1 even when direction bit i is 1.
- R5: With periph_sel[i]=1 and periph_force_in[i]=1, pin_oe[i] is 0 even when direction bit i is 0 or periph_force_out[i] is also 1.
- R6: With periph_sel[i]=0, periph_force_out[i], periph_force_in[i] and periph_dout[i] have no effect on pin_oe[i] or pin_out[i].
- R7: With periph_sel[i]=1 and neither force bit set, pin_oe[i] equals the inverse of direction bit i.
- R8: A bus read with bus_addr=1 returns the stored direction latch, not the effective direction while an override is active.
- R9: The direction latch changes only on a bus write with bus_addr=1. When an override is removed, pin_oe follows the stored direction bit again in the same cycle.
- R10: periph_din equals pin_in combinationally, in every mode.
- R11: A bus read with bus_addr=0 returns pin_in as it was SYNC_STAGES clock edges earlier (default 2).
- R12: A write with bus_addr=0 updates only the output-value latch, and a write with bus_addr=1 updates only the direction latch. Each takes effect at the clock edge where bus_wr is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 = output-value latch / pin levels, 1 = direction latch |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| periph_sel | input | 8 | Per-bit hand-over of the pin to the peripheral |
| periph_dout | input | 8 | Peripheral output value |
| periph_force_out | input | 8 | Peripheral request to drive the pin (only while selected) |
| periph_force_in | input | 8 | Peripheral request to float the pin (only while selected, wins) |
| periph_din | output | 8 | Pin level delivered to the peripheral |
| pin_in | input | 8 | Level sensed at the pad |
| pin_out | output | 8 | Value presented to the pad driver |
| pin_oe | output | 8 | Pad driver enable, 1 = drive |

## Verification
The assertions assume that the peripheral controls are free per bit and may change in any cycle, including both force bits set together. They do not assume that the override inputs are steady across bus writes. The stimulus changes the select, force and data inputs only on the falling clock edge, so every combinational relation is settled before the next sampling edge. Bus writes are one-cycle strobes that are also launched on the falling edge. pin_in is held steady for more than SYNC_STAGES edges before a port read is compared.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;

  typedef enum logic {
    REG_PORT = 1'b0,
    REG_DIR  = 1'b1
  } reg_sel_e;

  // Effective drive enable for one pin.
  function automatic logic pin_drive_en(input logic sel, input logic f_out,
                                        input logic f_in, input logic dir);
    logic en;
    if (!sel)       en = ~dir;
    else if (f_in)  en = 1'b0;
    else if (f_out) en = 1'b1;
    else            en = ~dir;
    return en;
  endfunction

  // Output value source for one pin.
  function automatic logic pin_drive_val(input logic sel, input logic periph_v,
                                         input logic latch_v);
    return sel ? periph_v : latch_v;
  endfunction

endpackage

// File: rtl/port_latch_bank.sv
module port_latch_bank
  import pinmux_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  reg_sel_e         wr_sel,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] data_q,
  output logic [WIDTH-1:0] dir_q
);

  localparam logic [WIDTH-1:0] DIR_RST  = '1;
  localparam logic [WIDTH-1:0] DATA_RST = '0;

  logic wr_data;
  logic wr_dir;

  assign wr_data = wr_en && (wr_sel == REG_PORT);
  assign wr_dir  = wr_en && (wr_sel == REG_DIR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= DATA_RST;
    end else if (wr_data) begin
      data_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= DIR_RST;
    end else if (wr_dir) begin
      dir_q <= wdata;
    end
  end

endmodule

// File: rtl/pin_drive_slice.sv
module pin_drive_slice
  import pinmux_pkg::*;
(
  input  logic sel,
  input  logic f_out,
  input  logic f_in,
  input  logic dir,
  input  logic latch_v,
  input  logic periph_v,
  output logic oe,
  output logic val,
  output logic overridden
);

  always_comb begin
    oe         = pin_drive_en(sel, f_out, f_in, dir);
    val        = pin_drive_val(sel, periph_v, latch_v);
    overridden = sel & (f_in | f_out);
  end

endmodule

// File: rtl/pin_in_sync.sv
module pin_in_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign q = d;
    end else begin : g_chain
      logic [WIDTH-1:0] stage_q [STAGES];
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            stage_q[s] <= '0;
          end else if (s == 0) begin
            stage_q[s] <= d;
          end else begin
            stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
          end
        end
      end
      assign q = stage_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/pinmux_port.sv
module pinmux_port
  import pinmux_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_addr,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  input  logic [WIDTH-1:0] periph_sel,
  input  logic [WIDTH-1:0] periph_dout,
  input  logic [WIDTH-1:0] periph_force_out,
  input  logic [WIDTH-1:0] periph_force_in,
  output logic [WIDTH-1:0] periph_din,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe
);

  // Named internal events, visible to the bound checker.
  logic [WIDTH-1:0] data_q;
  logic [WIDTH-1:0] dir_q;
  logic [WIDTH-1:0] pin_sync;
  logic [WIDTH-1:0] ovr_active;
  reg_sel_e         addr_sel;

  assign addr_sel = reg_sel_e'(bus_addr);

  port_latch_bank #(.WIDTH(WIDTH)) u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (bus_wr),
    .wr_sel (addr_sel),
    .wdata  (bus_wdata),
    .data_q (data_q),
    .dir_q  (dir_q)
  );

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      pin_drive_slice u_slice (
        .sel        (periph_sel[i]),
        .f_out      (periph_force_out[i]),
        .f_in       (periph_force_in[i]),
        .dir        (dir_q[i]),
        .latch_v    (data_q[i]),
        .periph_v   (periph_dout[i]),
        .oe         (pin_oe[i]),
        .val        (pin_out[i]),
        .overridden (ovr_active[i])
      );
    end
  endgenerate

  pin_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (pin_sync)
  );

  assign periph_din = pin_in;

  always_comb begin
    unique case (addr_sel)
      REG_DIR:  bus_rdata = dir_q;
      default:  bus_rdata = pin_sync;
    endcase
  end

endmodule

// File: rtl/pinmux_port_chk.sv
module pinmux_port_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic             bus_addr,
  input logic [WIDTH-1:0] periph_sel,
  input logic [WIDTH-1:0] periph_force_out,
  input logic [WIDTH-1:0] periph_force_in,
  input logic [WIDTH-1:0] pin_out,
  input logic [WIDTH-1:0] pin_oe,
  input logic [WIDTH-1:0] data_q,
  input logic [WIDTH-1:0] dir_q,
  input logic [WIDTH-1:0] ovr_active
);

  AST_UNSEL_OE_FOLLOWS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    ((~periph_sel) & (pin_oe ^ ~dir_q)) == '0);  // R2
  AST_UNSEL_OUT_FROM_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ((~periph_sel) & (pin_out ^ data_q)) == '0);  // R6
  AST_FORCE_OUT_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (periph_sel & periph_force_out & ~periph_force_in & ~pin_oe) == '0);  // R4
  AST_FORCE_IN_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
    (periph_sel & periph_force_in & pin_oe) == '0);  // R5
  AST_NO_OVR_FOLLOWS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    ((~ovr_active) & (pin_oe ^ ~dir_q)) == '0);  // R7
  AST_DIR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr) |=> $stable(dir_q));  // R9
  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && !bus_addr) |=> $stable(data_q));  // R12

endmodule

bind pinmux_port pinmux_port_chk #(.WIDTH(WIDTH)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .bus_wr           (bus_wr),
  .bus_addr         (bus_addr),
  .periph_sel       (periph_sel),
  .periph_force_out (periph_force_out),
  .periph_force_in  (periph_force_in),
  .pin_out          (pin_out),
  .pin_oe           (pin_oe),
  .data_q           (data_q),
  .dir_q            (dir_q),
  .ovr_active       (ovr_active)
);

// File: tb/test_pinmux_port.sv
`timescale 1ns/1ps
module test_pinmux_port;

  localparam int W    = 8;
  localparam int SYNC = 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_wr = 1'b0;
  logic         bus_addr = 1'b0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] bus_rdata;
  logic [W-1:0] periph_sel = '0;
  logic [W-1:0] periph_dout = '0;
  logic [W-1:0] periph_force_out = '0;
  logic [W-1:0] periph_force_in = '0;
  logic [W-1:0] periph_din;
  logic [W-1:0] pin_in = '0;
  logic [W-1:0] pin_out;
  logic [W-1:0] pin_oe;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pinmux_port #(.WIDTH(W), .SYNC_STAGES(SYNC)) i_pinmux_port (.*);

  // Bench model of the state written over the bus.
  logic [W-1:0] m_data = '0;
  logic [W-1:0] m_dir  = '1;

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Expected drive enable, written bit by bit from the requirements.
  function automatic logic [W-1:0] exp_oe();
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) begin
      if (periph_sel[i] && periph_force_in[i])       r[i] = 1'b0;
      else if (periph_sel[i] && periph_force_out[i]) r[i] = 1'b1;
      else                                           r[i] = !m_dir[i];
    end
    return r;
  endfunction

  function automatic logic [W-1:0] exp_out();
    return (periph_sel & periph_dout) | (~periph_sel & m_data);
  endfunction

  task automatic bus_write(input logic a, input logic [W-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    if (a) m_dir = d; else m_data = d;
    #1;
  endtask

  task automatic bus_read(input logic a, output logic [W-1:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic set_periph(input logic [W-1:0] s, input logic [W-1:0] dv,
                            input logic [W-1:0] fo, input logic [W-1:0] fi);
    @(negedge clk);
    periph_sel = s; periph_dout = dv; periph_force_out = fo; periph_force_in = fi;
    #1;
  endtask

  task automatic t_reset();
    logic [W-1:0] rd;
    bus_read(1'b1, rd);
    check("R1 dir reset", rd, '1);
    check("R1 oe reset", pin_oe, '0);
    check("R1 out reset", pin_out, '0);
  endtask

  task automatic t_port_mode();
    bus_write(1'b0, 8'hA5);
    bus_write(1'b1, 8'h0F);
    check("R2 oe from dir", pin_oe, 8'hF0);
    check("R2 out from latch", pin_out, 8'hA5);
    check("R12 data after dir write", pin_out, m_data);
  endtask

  task automatic t_unsel_ignored();
    set_periph(8'h00, 8'h5A, 8'hFF, 8'h0F);
    check("R6 oe unaffected", pin_oe, 8'hF0);
    check("R6 out unaffected", pin_out, 8'hA5);
  endtask

  task automatic t_periph_data();
    set_periph(8'h3C, 8'hFF, 8'h00, 8'h00);
    check("R3 out muxed", pin_out, exp_out());
    check("R7 oe from dir when selected", pin_oe, exp_oe());
  endtask

  task automatic t_force_out();
    logic [W-1:0] rd;
    set_periph(8'hFF, 8'h00, 8'h0F, 8'h00);   // dir bits 3:0 are 1
    check("R4 forced drive", pin_oe, 8'hFF);
    bus_read(1'b1, rd);
    check("R8 dir readback under force", rd, 8'h0F);
  endtask

  task automatic t_force_in();
    set_periph(8'hFF, 8'h00, 8'h00, 8'hF0);   // dir bits 7:4 are 0
    check("R5 forced float", pin_oe, 8'h00);
    set_periph(8'hFF, 8'h00, 8'hFF, 8'h81);
    check("R5 force-in wins", pin_oe, 8'h7E);
    check("R5 vs model", pin_oe, exp_oe());
  endtask

  task automatic t_release();
    set_periph(8'h00, 8'h00, 8'h00, 8'h00);
    check("R9 oe back to stored dir", pin_oe, 8'hF0);
    check("R9 out back to latch", pin_out, 8'hA5);
  endtask

  task automatic t_write_isolation();
    logic [W-1:0] rd;
    bus_write(1'b0, 8'h3C);
    bus_read(1'b1, rd);
    check("R12 dir kept on data write", rd, 8'h0F);
    check("R12 data written", pin_out, 8'h3C);
    bus_write(1'b1, 8'hC3);
    check("R12 data kept on dir write", pin_out, 8'h3C);
    check("R12 dir written", pin_oe, 8'h3C);
  endtask

  task automatic t_inputs();
    logic [W-1:0] rd;
    @(negedge clk);
    pin_in = 8'h96;
    bus_addr = 1'b0;
    #1;
    check("R10 periph_din immediate", periph_din, 8'h96);
    check("R11 port read before sync", bus_rdata, 8'h00);
    repeat (SYNC) @(posedge clk);
    @(negedge clk);
    bus_read(1'b0, rd);
    check("R11 port read after sync", rd, 8'h96);
    set_periph(8'hFF, 8'h00, 8'hFF, 8'h00);
    pin_in = 8'h69;
    #1;
    check("R10 periph_din in periph mode", periph_din, 8'h69);
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    t_reset();
    t_port_mode();
    t_unsel_ignored();
    t_periph_data();
    t_force_out();
    t_force_in();
    t_release();
    t_write_isolation();
    t_inputs();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule